// File: doc/BRIEF.md
# Dual Interval Timer with Compare

Two identical interval timers share one byte-wide register window. Each timer holds a 24-bit counter, a 24-bit compare value and a 24-bit preset. On every clock where its run bit is set and its own tick enable input is high, the counter moves by one, either up or down. The two tick enables are independent. In the intended system one is held high so that timer counts every pixel clock, and the other pulses once per video frame. This block does not generate either tick.

The counter is compared with the compare value at all times. The status byte shows the result. A separate output gives a one-cycle interrupt pulse when the two become equal. A tick that arrives while the counter sits on the compare value can clear the counter to zero, or reload it from the preset. This makes the timer periodic. Multi-byte fields are reached one byte at a time and no byte is latched, so a running counter can move between two byte accesses.

Address bit 3 selects the timer. Address bits 2:0 select the register: 0 is control on write and status on read, 1 to 3 are the counter bytes with the least significant byte first, 4 is match control, and 5 to 7 are the compare bytes with the least significant byte first. Reads are combinational from the address.

Top module: `ivt_pair`

## Requirements
- R1: After reset every counter, compare value, preset, run bit, direction bit and match-control bit is zero, both interrupt outputs are low, and the status byte of each timer reads 0x01.
- R2: A timer whose run bit (control bit 0) and up bit (control bit 3) are set goes up by one on each clock where its tick input is high, and wraps from 0xFFFFFF to 0. When the tick input is low, or the run bit is clear, the counter holds its value.
- R3: When the up bit is clear, a running timer goes down by one per tick and wraps from 0 to 0xFFFFFF.
- R4: Writing control with bit 1 set makes the counter zero on the next clock. Writing control with bit 2 set and bit 1 clear copies the compare value into the counter on the next clock. Bit 1 wins when both are set.
- R5: A write to counter byte k (offsets 1 to 3, k = offset-1) replaces bits 8k+7:8k of both the counter and the preset. The other counter bytes keep their values.
- R6: A read of offset 0 returns 0x01 when the counter equals the compare value and 0x00 otherwise. The flag stays set for as long as the two stay equal.
- R7: The interrupt output of a timer goes high for exactly one cycle, in the cycle where counter and compare first become equal.
- R8: When match-control bit 1 is set, a tick that arrives while the counter equals the compare value makes the counter zero instead of stepping it. This takes priority over R9.
- R9: When match-control bit 0 is set and bit 1 is clear, a tick that arrives while the counter equals the compare value loads the preset instead of stepping the counter.
- R10: Address bit 3 selects timer 1 and each timer counts only on its own tick input. Accesses to one timer leave the other timer's registers and interrupt output unchanged.
- R11: The compare bytes (offsets 5 to 7, least significant byte first) and the match-control byte (offset 4, bits 1:0) read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 2 | Per-timer count enable, bit t drives timer t |
| addr_i | input | 4 | Register address, bit 3 selects the timer |
| wr_i | input | 1 | Write strobe for the addressed byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed byte, combinational |
| irq_o | output | 2 | Per-timer match pulse |

## Verification
A write or a tick seen at clock edge N shows up in the register state and in the read data right after edge N. The interrupt pulse appears in that same cycle, because it is registered from the next-state values. The bench samples its inputs at each rising edge and advances a behavioural model from them. One time unit later it compares the read data for the current address and both interrupt outputs against that model. Inputs change only on falling edges. Directed checks on stopped timers use byte values worked out by hand. Checks on running timers count how many ticks fall between the start and stop writes, and count interrupt pulses over windows that hold a whole number of periods.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int BYTE_W = 8;

    // control byte bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_ZERO = 1;
    localparam int CTL_LOAD = 2;
    localparam int CTL_UP   = 3;

    // match-control byte bit positions
    localparam int MCTL_RELOAD = 0;
    localparam int MCTL_ZERO   = 1;

    typedef enum logic [2:0] {
        KIND_CTRL  = 3'd0,
        KIND_COUNT = 3'd1,
        KIND_MCTL  = 3'd2,
        KIND_CMP   = 3'd3,
        KIND_NONE  = 3'd4
    } reg_kind_e;
endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
    import ivt_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int NB       = 3,
    parameter int WIN_W    = 3,
    parameter int TS_W     = 1,
    parameter int IDX_W    = 2
) (
    input  logic [TS_W+WIN_W-1:0] addr_i,
    input  logic                  wr_i,
    output logic [TS_W-1:0]       tsel_o,
    output reg_kind_e             kind_o,
    output logic [IDX_W-1:0]      idx_o,
    output logic [N_TIMERS-1:0]   wr_vec_o
);
    localparam int LOW_W = WIN_W - 1;

    logic             hi_half;
    logic [LOW_W-1:0] low_ofs;

    assign tsel_o  = addr_i[TS_W+WIN_W-1:WIN_W];
    assign hi_half = addr_i[WIN_W-1];
    assign low_ofs = addr_i[LOW_W-1:0];

    always_comb begin
        kind_o = KIND_NONE;
        idx_o  = '0;
        if (low_ofs == '0) begin
            kind_o = hi_half ? KIND_MCTL : KIND_CTRL;
        end else if (int'(low_ofs) <= NB) begin
            kind_o = hi_half ? KIND_CMP : KIND_COUNT;
            idx_o  = IDX_W'(int'(low_ofs) - 1);
        end
    end

    always_comb begin
        wr_vec_o = '0;
        for (int t = 0; t < N_TIMERS; t++) begin
            if (wr_i && tsel_o == TS_W'(t)) wr_vec_o[t] = 1'b1;
        end
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int NB    = CNT_W / BYTE_W,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  reg_kind_e         kind_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              eq_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] pre;
        logic             run;
        logic             up;
        logic             rld;
        logic             clrm;
        logic             irq;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic eq_now, wr_ctl, wr_cnt, wr_mctl, wr_cmp, step_en;

    always_comb begin
        eq_now  = (st_q.cnt == st_q.cmp);
        wr_ctl  = wr_i && (kind_i == KIND_CTRL);
        wr_cnt  = wr_i && (kind_i == KIND_COUNT);
        wr_mctl = wr_i && (kind_i == KIND_MCTL);
        wr_cmp  = wr_i && (kind_i == KIND_CMP);
        step_en = st_q.run && tick_i;

        st_d = st_q;

        // counter next value, in priority order
        if (wr_ctl && wdata_i[CTL_ZERO]) begin
            st_d.cnt = '0;
        end else if (wr_ctl && wdata_i[CTL_LOAD]) begin
            st_d.cnt = st_q.cmp;
        end else if (wr_cnt) begin
            for (int b = 0; b < NB; b++) begin
                if (idx_i == IDX_W'(b)) begin
                    st_d.cnt[b*BYTE_W +: BYTE_W] = wdata_i;
                    st_d.pre[b*BYTE_W +: BYTE_W] = wdata_i;
                end
            end
        end else if (step_en) begin
            if (eq_now && st_q.clrm) begin
                st_d.cnt = '0;
            end else if (eq_now && st_q.rld) begin
                st_d.cnt = st_q.pre;
            end else if (st_q.up) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        if (wr_cmp) begin
            for (int b = 0; b < NB; b++) begin
                if (idx_i == IDX_W'(b)) st_d.cmp[b*BYTE_W +: BYTE_W] = wdata_i;
            end
        end

        if (wr_ctl) begin
            st_d.run = wdata_i[CTL_RUN];
            st_d.up  = wdata_i[CTL_UP];
        end

        if (wr_mctl) begin
            st_d.rld  = wdata_i[MCTL_RELOAD];
            st_d.clrm = wdata_i[MCTL_ZERO];
        end

        // pulse in the cycle where equality first holds
        st_d.irq = (st_d.cnt == st_d.cmp) && !eq_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (kind_i)
            KIND_CTRL: rdata_o[0] = eq_now;
            KIND_COUNT: begin
                for (int b = 0; b < NB; b++) begin
                    if (idx_i == IDX_W'(b)) rdata_o = st_q.cnt[b*BYTE_W +: BYTE_W];
                end
            end
            KIND_MCTL: begin
                rdata_o[MCTL_RELOAD] = st_q.rld;
                rdata_o[MCTL_ZERO]   = st_q.clrm;
            end
            KIND_CMP: begin
                for (int b = 0; b < NB; b++) begin
                    if (idx_i == IDX_W'(b)) rdata_o = st_q.cmp[b*BYTE_W +: BYTE_W];
                end
            end
            default: rdata_o = '0;
        endcase
    end

    assign eq_o  = eq_now;
    assign irq_o = st_q.irq;

    // ---------------- assertions ----------------
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata_i[CTL_ZERO]) |=> (st_q.cnt == '0));

    assert_load_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !wdata_i[CTL_ZERO] && wdata_i[CTL_LOAD]) |=> (st_q.cnt == $past(st_q.cmp)));

    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && st_q.run && tick_i && st_q.up && !eq_o)
        |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + CNT_W'(1))));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && st_q.run && tick_i && !st_q.up && !eq_o)
        |=> (st_q.cnt == CNT_W'($past(st_q.cnt) - CNT_W'(1))));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !(st_q.run && tick_i)) |=> $stable(st_q.cnt));

    assert_match_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && st_q.run && tick_i && eq_o && st_q.clrm) |=> (st_q.cnt == '0));

    assert_match_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && st_q.run && tick_i && eq_o && !st_q.clrm && st_q.rld)
        |=> (st_q.cnt == $past(st_q.pre)));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_with_eq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> eq_o);
endmodule

// File: rtl/ivt_pair.sv
module ivt_pair
    import ivt_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int CNT_W    = 24,
    localparam int NB      = CNT_W / BYTE_W,
    localparam int WIN_W   = $clog2(2 * (NB + 1)),
    localparam int TS_W    = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1,
    localparam int IDX_W   = (NB > 1) ? $clog2(NB) : 1,
    localparam int ADDR_W  = TS_W + WIN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_TIMERS-1:0] tick_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_i,
    input  logic [BYTE_W-1:0]   wdata_i,
    output logic [BYTE_W-1:0]   rdata_o,
    output logic [N_TIMERS-1:0] irq_o
);
    logic [TS_W-1:0]                 tsel;
    reg_kind_e                       kind;
    logic [IDX_W-1:0]                idx;
    logic [N_TIMERS-1:0]             wr_vec;
    logic [N_TIMERS-1:0][BYTE_W-1:0] ch_rd;
    logic [N_TIMERS-1:0]             ch_eq;

    ivt_decode #(
        .N_TIMERS(N_TIMERS), .NB(NB), .WIN_W(WIN_W), .TS_W(TS_W), .IDX_W(IDX_W)
    ) u_decode (
        .addr_i  (addr_i),
        .wr_i    (wr_i),
        .tsel_o  (tsel),
        .kind_o  (kind),
        .idx_o   (idx),
        .wr_vec_o(wr_vec)
    );

    for (genvar t = 0; t < N_TIMERS; t++) begin : g_chan
        ivt_channel #(
            .CNT_W(CNT_W), .NB(NB), .IDX_W(IDX_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i[t]),
            .wr_i   (wr_vec[t]),
            .kind_i (kind),
            .idx_i  (idx),
            .wdata_i(wdata_i),
            .rdata_o(ch_rd[t]),
            .eq_o   (ch_eq[t]),
            .irq_o  (irq_o[t])
        );

        // a write to another timer leaves this one's interrupt quiet unless it ticks
        assert_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_vec[t] && !tick_i[t] && ch_eq[t]) |=> !irq_o[t]);
    end

    always_comb begin
        rdata_o = '0;
        for (int t = 0; t < N_TIMERS; t++) begin
            if (tsel == TS_W'(t)) rdata_o = ch_rd[t];
        end
    end
endmodule

// File: tb/ivt_pair_tb.sv
module ivt_pair_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tick = 2'b00;
    logic [3:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivt_pair u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .addr_i(addr),
        .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [23:0] m_cnt [2];
    logic [23:0] m_cmp [2];
    logic [23:0] m_pre [2];
    bit m_run [2], m_up [2], m_rld [2], m_clrm [2], m_irq [2];
    bit tick0_on = 0;
    int frame_div = 0;
    bit win = 0;
    int irq_seen [2];

    function automatic logic [7:0] model_read(logic [3:0] a);
        int t = a[3];
        int o = a[2:0];
        if (o == 0) return {7'b0, m_cnt[t] == m_cmp[t]};
        if (o <= 3) return m_cnt[t][(o-1)*8 +: 8];
        if (o == 4) return {6'b0, m_clrm[t], m_rld[t]};
        return m_cmp[t][(o-5)*8 +: 8];
    endfunction

    function automatic string read_req(logic [3:0] a);
        int o = a[2:0];
        if (o == 0) return "R6";
        if (o <= 3) return "R2";
        return "R11";
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            frame_div = (frame_div + 1) % 8;
            tick[1] <= (frame_div == 0);
            tick[0] <= tick0_on;
        end
    end

    always @(posedge clk) begin
        logic s_wr, s_rst;
        logic [3:0] s_addr;
        logic [7:0] s_wd;
        logic [1:0] s_tick;
        s_wr = wr; s_addr = addr; s_wd = wdata; s_tick = tick; s_rst = rst_n;
        #1;
        if (!s_rst) begin
            for (int t = 0; t < 2; t++) begin
                m_cnt[t] = 0; m_cmp[t] = 0; m_pre[t] = 0;
                m_run[t] = 0; m_up[t] = 0; m_rld[t] = 0; m_clrm[t] = 0; m_irq[t] = 0;
            end
        end else begin
            for (int t = 0; t < 2; t++) begin
                logic [23:0] c, n, k;
                bit sel;
                int o;
                c = m_cnt[t]; n = c; k = m_cmp[t];
                sel = s_wr && (s_addr[3] == t[0]);
                o = s_addr[2:0];
                if (sel && o == 0 && s_wd[1]) n = 0;
                else if (sel && o == 0 && s_wd[2]) n = m_cmp[t];
                else if (sel && o >= 1 && o <= 3) begin
                    n[(o-1)*8 +: 8] = s_wd;
                    m_pre[t][(o-1)*8 +: 8] = s_wd;
                end else if (m_run[t] && s_tick[t]) begin
                    if (c == m_cmp[t] && m_clrm[t]) n = 0;
                    else if (c == m_cmp[t] && m_rld[t]) n = m_pre[t];
                    else if (m_up[t]) n = c + 24'd1;
                    else n = c - 24'd1;
                end
                if (sel && o >= 5) k[(o-5)*8 +: 8] = s_wd;
                if (sel && o == 0) begin m_run[t] = s_wd[0]; m_up[t] = s_wd[3]; end
                if (sel && o == 4) begin m_rld[t] = s_wd[0]; m_clrm[t] = s_wd[1]; end
                m_irq[t] = (n == k) && (c != m_cmp[t]);
                m_cnt[t] = n; m_cmp[t] = k;
            end
            chk(read_req(addr), rdata, model_read(addr));
            chk("R7", irq[0], m_irq[0]);
            chk("R7", irq[1], m_irq[1]);
            if (win) begin
                irq_seen[0] += irq[0];
                irq_seen[1] += irq[1];
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_reg(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_count(logic [3:0] base, logic [23:0] v);
        wr_reg(base + 4'd1, v[7:0]);
        wr_reg(base + 4'd2, v[15:8]);
        wr_reg(base + 4'd3, v[23:16]);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick0_on = 1;

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd_reg(4'(a), v);
            chk("R1", v, (a == 0 || a == 8) ? 8'h01 : 8'h00);
        end
        chk("R1", irq, 2'b00);

        // R11 compare and match-control readback
        wr_reg(4'd5, 8'h10); wr_reg(4'd6, 8'h20); wr_reg(4'd7, 8'h30);
        rd_reg(4'd5, v); chk("R11", v, 8'h10);
        rd_reg(4'd7, v); chk("R11", v, 8'h30);
        wr_reg(4'd4, 8'h03);
        rd_reg(4'd4, v); chk("R11", v, 8'h03);
        wr_reg(4'd4, 8'h00);

        // R5 byte writes on a stopped timer; R6 status when unequal
        set_count(4'd0, 24'hCCBBAA);
        rd_reg(4'd1, v); chk("R5", v, 8'hAA);
        rd_reg(4'd2, v); chk("R5", v, 8'hBB);
        rd_reg(4'd3, v); chk("R5", v, 8'hCC);
        rd_reg(4'd0, v); chk("R6", v, 8'h00);

        // R4 load then clear-over-load
        wr_reg(4'd0, 8'h04);
        rd_reg(4'd1, v); chk("R4", v, 8'h10);
        rd_reg(4'd3, v); chk("R4", v, 8'h30);
        rd_reg(4'd0, v); chk("R6", v, 8'h01);
        wr_reg(4'd0, 8'h06);
        rd_reg(4'd2, v); chk("R4", v, 8'h00);

        // R2 up count with wrap: three ticks from 0xFFFFFE
        set_count(4'd0, 24'hFFFFFE);
        wr_reg(4'd0, 8'h09); idle(1); wr_reg(4'd0, 8'h08);
        rd_reg(4'd1, v); chk("R2", v, 8'h01);
        rd_reg(4'd3, v); chk("R2", v, 8'h00);

        // R3 down count with wrap: three ticks from 1
        set_count(4'd0, 24'h000001);
        wr_reg(4'd0, 8'h01); idle(1); wr_reg(4'd0, 8'h00);
        rd_reg(4'd1, v); chk("R3", v, 8'hFE);
        rd_reg(4'd3, v); chk("R3", v, 8'hFF);

        // R8 clear-on-match, period 5 ticks; R7 pulse count
        wr_reg(4'd5, 8'h04); wr_reg(4'd6, 8'h00); wr_reg(4'd7, 8'h00);
        wr_reg(4'd4, 8'h02);
        set_count(4'd0, 24'h0);
        wr_reg(4'd0, 8'h09);
        irq_seen[0] = 0; irq_seen[1] = 0;
        win = 1; idle(50); win = 0;
        chk("R8", irq_seen[0], 10);
        wr_reg(4'd0, 8'h08);

        // R9 reload-on-match from preset 2, period 3 ticks
        set_count(4'd0, 24'h000002);
        wr_reg(4'd4, 8'h01);
        wr_reg(4'd0, 8'h09);
        irq_seen[0] = 0;
        win = 1; idle(60); win = 0;
        chk("R9", irq_seen[0], 20);
        wr_reg(4'd0, 8'h00);
        rd_reg(4'd1, v);

        // R10 timer 1 on the frame tick, timer 0 stopped
        wr_reg(4'd13, 8'h03);
        wr_reg(4'd12, 8'h02);
        wr_reg(4'd8, 8'h09);
        irq_seen[0] = 0; irq_seen[1] = 0;
        win = 1; idle(160); win = 0;
        chk("R10", irq_seen[1], 5);
        chk("R10", irq_seen[0], 0);
        rd_reg(4'd1, v2); chk("R10", v2, v);
        rd_reg(4'd5, v2); chk("R10", v2, 8'h04);
        wr_reg(4'd8, 8'h00);
        idle(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule